// File: doc/BRIEF.md
# PWM Sequence Value Decoder

This block sits between a small sample memory and a four-channel pulse generator. When it is started it reads a sequence of 16-bit halfwords through a synchronous read port. Reading begins at a programmed base address and covers a programmed number of halfwords. The block gathers the halfwords into groups and spreads each group over four channel compare words, following a load layout. In one layout the fourth halfword becomes the pulse-generator counter top instead of a channel value.

A new group takes effect only on a period-end strobe from the pulse generator. Stepping to the next group can happen in two ways. In automatic mode it happens after the current group has been held for a programmed number of extra periods. In triggered mode it happens at the first period end after an external next-step pulse. After the final group the value is held for an end delay. The block then pulses a done strobe, which the playback controller uses to chain or stop playback. A stop input aborts playback at once.

Top module: `pwm_seq_decoder`

## Requirements
- R1: After reset all compare words and the top word are zero, and top_valid, mem_rd_en, last_rd and seq_done are low.
- R2: After start, the block reads the halfwords at cfg_base, cfg_base+1, and so on up to cfg_base+cfg_len-1. It issues one read per cycle within a group, and reads each address exactly once. The read data arrives one cycle after the request. cfg_len is nonzero and is a multiple of the group size (1, 2, 4, 4 for cfg_load 0, 1, 2, 3), and it holds with the other configuration while playback runs.
- R3: With cfg_load=0 (common), each halfword is driven to all four channels.
- R4: With cfg_load=1 (grouped), the first halfword of a pair drives channels 0 and 1, and the second drives channels 2 and 3.
- R5: With cfg_load=2 (individual), four consecutive halfwords drive channels 0, 1, 2 and 3 in that order.
- R6: With cfg_load=3 (waveform), the first three halfwords of a quad drive channels 0 to 2 and channel 3 is driven to zero. The fourth halfword appears on top_o with top_valid high. A group applied in any other layout drops top_valid and leaves top_o unchanged.
- R7: Compare words, top_o and top_valid change only in the cycle after a period_end strobe, with all channels of a group changing together. The first group is applied at the first period_end after start.
- R8: With cfg_step_trig=0, every group except the last is held for cfg_refresh+1 periods before the next group is applied.
- R9: With cfg_step_trig=1, the next group is applied at the first period_end after a next_step pulse, and cfg_refresh and cfg_end_delay have no effect. With cfg_step_trig=0, next_step has no effect.
- R10: In automatic mode the last group is held for cfg_refresh+cfg_end_delay+1 periods. In triggered mode it is held until the first period_end after a next_step pulse. seq_done is then high for one cycle, the cycle after that period_end.
- R11: last_rd is high exactly in the cycle in which the read of address cfg_base+cfg_len-1 is issued.
- R12: stop ends playback at that clock edge. No further reads are issued, seq_done does not pulse, and the compare words keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback (taken while idle) |
| stop | input | 1 | Abort playback; has priority over start |
| period_end | input | 1 | One-cycle strobe at each pulse-generator period boundary |
| next_step | input | 1 | Advance request used in triggered mode |
| cfg_load | input | 2 | Load layout: 0 common, 1 grouped, 2 individual, 3 waveform |
| cfg_step_trig | input | 1 | 0 automatic stepping, 1 triggered stepping |
| cfg_base | input | AW | Address of the first halfword |
| cfg_len | input | LW | Number of halfwords in the sequence |
| cfg_refresh | input | RW | Extra periods each group is held (automatic mode) |
| cfg_end_delay | input | RW | Extra periods the last group is held (automatic mode) |
| mem_rd_en | output | 1 | Read request |
| mem_addr | output | AW | Read address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| cmp_o | output | 64 | Four compare words, channel n at bits 16n+15:16n |
| top_o | output | 16 | Counter top from the waveform layout |
| top_valid | output | 1 | top_o applies (last group was waveform) |
| last_rd | output | 1 | Read of the final halfword issued this cycle |
| seq_done | output | 1 | One-cycle pulse when the end hold has elapsed |

## Verification
The bench runs all four layouts and compares the compare words against a reference model on every clock. A wrong fan-out shows up as the wrong halfword on some channel, and a waveform layout that leaks its fourth word into channel 3 is also caught. The hold counts are checked at their edges. An off-by-one in the repeat or end-delay comparison moves a group change or the done pulse by a whole period. A triggered-mode decoder that still obeys the repeat count advances early. A next-step input that leaks into automatic mode shortens a hold. Every read address and the position of last_rd are checked, as is a stop mid-sequence, where a faulty design keeps fetching or raises done.

// File: rtl/pwmseq_pkg.sv
package pwmseq_pkg;
    localparam int NCH = 4;
    localparam int HW  = 16;

    typedef enum logic [1:0] {
        LOAD_COMMON  = 2'd0,
        LOAD_GROUPED = 2'd1,
        LOAD_SINGLE  = 2'd2,
        LOAD_WAVE    = 2'd3
    } load_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_SETTLE,
        PH_READY,
        PH_HOLD
    } phase_e;

    typedef logic [NCH-1:0][HW-1:0] grp_t;

    // halfwords per group for each layout
    function automatic logic [2:0] group_words(load_e m);
        case (m)
            LOAD_COMMON:  return 3'd1;
            LOAD_GROUPED: return 3'd2;
            default:      return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/pwmseq_stage.sv
module pwmseq_stage
    import pwmseq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [1:0]    cap_slot,
    input  logic [HW-1:0] cap_data,
    output grp_t          stage_o
);
    grp_t stage_d, stage_q;

    always_comb begin
        stage_d = stage_q;
        if (cap_en) stage_d[cap_slot] = cap_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/pwmseq_fanout.sv
module pwmseq_fanout
    import pwmseq_pkg::*;
(
    input  load_e         mode,
    input  grp_t          stage_i,
    output grp_t          cmp_o,
    output logic [HW-1:0] top_o,
    output logic          top_vld_o
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [HW-1:0] val;
        always_comb begin
            case (mode)
                LOAD_COMMON:  val = stage_i[0];
                LOAD_GROUPED: val = stage_i[ch/2];
                LOAD_SINGLE:  val = stage_i[ch];
                default:      val = (ch == NCH-1) ? '0 : stage_i[ch];
            endcase
        end
        assign cmp_o[ch] = val;
    end

    assign top_o     = stage_i[NCH-1];
    assign top_vld_o = (mode == LOAD_WAVE);
endmodule

// File: rtl/pwm_seq_decoder.sv
module pwm_seq_decoder
    import pwmseq_pkg::*;
#(
    parameter int AW = 12,
    parameter int LW = 12,
    parameter int RW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            stop,
    input  logic            period_end,
    input  logic            next_step,
    input  logic [1:0]      cfg_load,
    input  logic            cfg_step_trig,
    input  logic [AW-1:0]   cfg_base,
    input  logic [LW-1:0]   cfg_len,
    input  logic [RW-1:0]   cfg_refresh,
    input  logic [RW-1:0]   cfg_end_delay,
    output logic            mem_rd_en,
    output logic [AW-1:0]   mem_addr,
    input  logic [15:0]     mem_rd_data,
    output logic [63:0]     cmp_o,
    output logic [15:0]     top_o,
    output logic            top_valid,
    output logic            last_rd,
    output logic            seq_done
);
    localparam int CW = RW + 1;

    typedef struct packed {
        phase_e        phase;
        logic [LW-1:0] ptr;
        logic [1:0]    slot;
        logic [CW-1:0] rep;
        logic          nxt;
        logic          applied;
        logic          rd_pend;
        logic [1:0]    rd_slot;
        grp_t          cmp;
        logic [HW-1:0] top;
        logic          top_vld;
        logic          done;
    } st_t;

    st_t q, d;

    load_e         mode;
    logic [2:0]    gsz;
    grp_t          stage;
    grp_t          fan_cmp;
    logic [HW-1:0] fan_top;
    logic          fan_tvld;
    logic          rd_en;
    logic          adv;
    logic          fin;

    assign mode = load_e'(cfg_load);
    assign gsz  = group_words(mode);

    pwmseq_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (q.rd_pend),
        .cap_slot (q.rd_slot),
        .cap_data (mem_rd_data),
        .stage_o  (stage)
    );

    pwmseq_fanout u_fan (
        .mode      (mode),
        .stage_i   (stage),
        .cmp_o     (fan_cmp),
        .top_o     (fan_top),
        .top_vld_o (fan_tvld)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.rd_pend = 1'b0;
        d.nxt     = (q.nxt & ~period_end) | next_step;
        rd_en     = 1'b0;
        adv       = !q.applied || (cfg_step_trig ? q.nxt : (q.rep == CW'(cfg_refresh)));
        fin       = cfg_step_trig ? q.nxt
                                  : (q.rep == CW'(cfg_refresh) + CW'(cfg_end_delay));
        case (q.phase)
            PH_IDLE: begin
                if (start) begin
                    d.phase   = PH_FETCH;
                    d.ptr     = '0;
                    d.slot    = '0;
                    d.rep     = '0;
                    d.nxt     = 1'b0;
                    d.applied = 1'b0;
                end
            end
            PH_FETCH, PH_SETTLE: begin
                if (q.phase == PH_FETCH) begin
                    rd_en     = 1'b1;
                    d.rd_pend = 1'b1;
                    d.rd_slot = q.slot;
                    d.ptr     = q.ptr + LW'(1);
                    d.slot    = q.slot + 2'd1;
                    if (3'(q.slot) == gsz - 3'd1) d.phase = PH_SETTLE;
                end else begin
                    d.phase = PH_READY;
                end
                if (period_end && q.applied) d.rep = q.rep + CW'(1);
            end
            PH_READY: begin
                if (period_end) begin
                    if (adv) begin
                        d.cmp     = fan_cmp;
                        d.top_vld = fan_tvld;
                        if (fan_tvld) d.top = fan_top;
                        d.rep     = '0;
                        d.applied = 1'b1;
                        d.slot    = '0;
                        d.phase   = (q.ptr == cfg_len) ? PH_HOLD : PH_FETCH;
                    end else begin
                        d.rep = q.rep + CW'(1);
                    end
                end
            end
            PH_HOLD: begin
                if (period_end) begin
                    if (fin) begin
                        d.phase = PH_IDLE;
                        d.done  = 1'b1;
                    end else begin
                        d.rep = q.rep + CW'(1);
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
        if (stop) begin
            rd_en     = 1'b0;
            d.rd_pend = 1'b0;
            d.phase   = PH_IDLE;
            d.done    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_en = rd_en;
    assign mem_addr  = cfg_base + AW'(q.ptr);
    assign last_rd   = rd_en && (q.ptr == cfg_len - LW'(1));
    assign cmp_o     = q.cmp;
    assign top_o     = q.top;
    assign top_valid = q.top_vld;
    assign seq_done  = q.done;
endmodule

// File: rtl/pwmseq_chk.sv
module pwmseq_chk #(
    parameter int AW = 12,
    parameter int LW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          period_end,
    input logic [1:0]    cfg_load,
    input logic [AW-1:0] cfg_base,
    input logic [LW-1:0] cfg_len,
    input logic          mem_rd_en,
    input logic [AW-1:0] mem_addr,
    input logic [63:0]   cmp_o,
    input logic [15:0]   top_o,
    input logic          top_valid,
    input logic          last_rd,
    input logic          seq_done
);
    logic [AW-1:0] rd_off;
    assign rd_off = mem_addr - cfg_base;

    // R2: every read stays inside the programmed window
    assert_addr_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(rd_off) < int'(cfg_len)));

    // R11: last-read flag marks the read of the final address
    assert_last_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        last_rd |-> (mem_rd_en && mem_addr == cfg_base + AW'(cfg_len - LW'(1))));

    // R7: outputs only move after a period boundary
    assert_cmp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ($stable(cmp_o) && $stable(top_o) && $stable(top_valid)));

    // R10: done follows a period boundary
    assert_done_after_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> $past(period_end));

    // R6: top becomes valid only through the waveform layout
    assert_top_wave_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(top_valid) |-> (cfg_load == 2'd3));
endmodule

bind pwm_seq_decoder pwmseq_chk #(.AW(AW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .cfg_load   (cfg_load),
    .cfg_base   (cfg_base),
    .cfg_len    (cfg_len),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .cmp_o      (cmp_o),
    .top_o      (top_o),
    .top_valid  (top_valid),
    .last_rd    (last_rd),
    .seq_done   (seq_done)
);

// File: tb/tb_pwm_seq_decoder.sv
module tb_pwm_seq_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int PER = 10;
    localparam int AW = 12, LW = 12, RW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, stop = 0, period_end = 0, next_step = 0;
    logic [1:0] cfg_load = 0;
    logic cfg_step_trig = 0;
    logic [AW-1:0] cfg_base = 0;
    logic [LW-1:0] cfg_len = 1;
    logic [RW-1:0] cfg_refresh = 0, cfg_end_delay = 0;
    logic mem_rd_en;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_rd_data = 0;
    logic [63:0] cmp_o;
    logic [15:0] top_o;
    logic top_valid, last_rd, seq_done;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_seq_decoder #(.AW(AW), .LW(LW), .RW(RW)) dut (.*);

    logic [15:0] mem [64];
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_addr[5:0]];

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    string tag = "R1";

    task automatic chk(bit ok, string t, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // reference model state
    bit m_run = 0, nxt = 0;
    int g = 0, rep = 0, nread = 0;
    logic [63:0] e_cmp = 0;
    logic [15:0] e_top = 0;
    logic e_tv = 0, e_done = 0;

    function automatic int gsize();
        return (cfg_load == 0) ? 1 : (cfg_load == 1) ? 2 : 4;
    endfunction

    task automatic apply_group(int gi);
        int o = int'(cfg_base) + gi * gsize();
        for (int ch = 0; ch < 4; ch++) begin
            logic [15:0] v;
            case (cfg_load)
                2'd0: v = mem[o];
                2'd1: v = mem[o + ch/2];
                2'd2: v = mem[o + ch];
                default: v = (ch == 3) ? 16'h0 : mem[o + ch];
            endcase
            e_cmp[ch*16 +: 16] = v;
        end
        e_tv = (cfg_load == 2'd3);
        if (e_tv) e_top = mem[o + 3];
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; nxt = 0; e_cmp = 0; e_top = 0; e_tv = 0; e_done = 0;
        end else begin
            e_done = 0;
            if (stop) m_run = 0;
            else if (start && !m_run) begin
                m_run = 1; g = 0; rep = 0; nxt = 0;
            end else if (m_run && period_end) begin
                if (g == 0) begin
                    apply_group(0); g = 1; rep = 0;
                end else if (g < int'(cfg_len) / gsize()) begin
                    if (cfg_step_trig ? nxt : (rep == int'(cfg_refresh))) begin
                        apply_group(g); g++; rep = 0;
                    end else rep++;
                end else begin
                    if (cfg_step_trig ? nxt : (rep == int'(cfg_refresh) + int'(cfg_end_delay))) begin
                        m_run = 0; e_done = 1;
                    end else rep++;
                end
            end
            if (period_end) nxt = 0;
            if (next_step) nxt = 1;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cmp_o === e_cmp, {tag, " cmp"}, cmp_o, e_cmp);
            chk(top_o === e_top && top_valid === e_tv, {tag, " R6 top"},
                {47'b0, top_valid, top_o}, {47'b0, e_tv, e_top});
            chk(seq_done === e_done, {tag, " R10 done"}, 64'(seq_done), 64'(e_done));
            if (mem_rd_en) begin
                chk(m_run, "R12 read while idle", 64'(mem_rd_en), 64'(0));
                chk(mem_addr === cfg_base + AW'(nread), "R2 address", 64'(mem_addr),
                    64'(cfg_base + AW'(nread)));
                chk(last_rd === (nread == int'(cfg_len) - 1), "R11 last_rd",
                    64'(last_rd), 64'(nread == int'(cfg_len) - 1));
                nread++;
            end else begin
                chk(last_rd === 1'b0, "R11 last_rd without read", 64'(last_rd), 64'(0));
            end
        end
    end

    task automatic run(input logic [1:0] ld, input bit trig, input int base, input int len,
                       input int rf, input int ed, input bit ns_en, input int stop_at,
                       input string t);
        @(posedge clk); #1;
        cfg_load = ld; cfg_step_trig = trig; cfg_base = AW'(base); cfg_len = LW'(len);
        cfg_refresh = RW'(rf); cfg_end_delay = RW'(ed); tag = t; nread = 0;
        for (int c = 0; c < 800; c++) begin
            @(posedge clk); #1;
            start      = (c == 0);
            period_end = (c % PER == PER - 1);
            next_step  = ns_en && (c % PER == 3) && ((c / PER) % 2 == 1);
            stop       = (c == stop_at);
            if (c > 2 && !m_run && !stop) break;
            if (c == 799) chk(0, {t, " R10 run did not finish"}, 0, 1);
        end
        start = 0; period_end = 0; next_step = 0; stop = 0;
        repeat (20) @(posedge clk);
        if (stop_at < 0) chk(nread == len, {t, " R2 read count"}, 64'(nread), 64'(len));
        else chk(nread < len, {t, " R12 reads after stop"}, 64'(nread), 64'(len));
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i * 16'h0137) ^ 16'hA5A5 ^ 16'(i << 12);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(cmp_o === 64'h0 && top_o === 16'h0, "R1 reset compare", cmp_o, 64'h0);
        chk({top_valid, mem_rd_en, last_rd, seq_done} === 4'b0, "R1 reset flags",
            64'({top_valid, mem_rd_en, last_rd, seq_done}), 64'h0);
        run(2'd0, 0, 2,  3, 1, 2, 0, -1, "R3 R7 R8 R10");
        run(2'd1, 0, 8,  4, 0, 0, 0, -1, "R4 R8 R10");
        run(2'd3, 1, 30, 8, 5, 7, 1, -1, "R6 R9 R10");
        run(2'd2, 0, 16, 8, 2, 1, 1, -1, "R5 R9 R8");
        run(2'd0, 0, 40, 6, 3, 0, 0, 45, "R12");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog R10 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule